// File: doc/BRIEF.md
# Indirect Address/Data Register Bridge

This block lets a host reach two large internal register spaces through a small window of six bus registers. Each space has its own channel, made of an address register, a data register and a control register. The host is an APB slave port. To reach an internal register, the host writes the target address into the channel's address register twice in a row. It then reads or writes the channel's data register. Each data access that is allowed becomes one transaction on that channel's back-end register port. The port carries a request, a write enable, an address, write data, read data, an acknowledge and an error flag.

Reads are pipelined. A data read returns the value fetched by the channel's previous data read, and starts a new fetch from the active address. The host therefore reads twice in a row to get the contents of one register. Channel A carries 32-bit values. Channel B carries 8-bit values, which are zero-extended on read. Each channel has an error-enable bit. When that bit is set, a back-end error or an out-of-range target address is reported on PSLVERR.

Each channel runs a three-state machine:
- **IDLE**: waits for an APB access phase. Address, control, unmapped, unarmed and out-of-range accesses complete here with no wait state.
- **BUSY**: holds the back-end request until the acknowledge arrives. PREADY is low in this state.
- **DONE**: drives the captured result with PREADY high, then returns to IDLE.

The transitions are:
- IDLE→BUSY on a data access that is armed and in range.
- BUSY→DONE on the acknowledge.
- DONE→IDLE always.

Top module: `idx_reg_bridge`

## Requirements
- R1: The register window is decoded from PADDR[4:0]. Channel A uses 0x00 (address), 0x04 (data) and 0x08 (control). Channel B uses 0x10, 0x14 and 0x18. Any other offset reads 0, has no effect, completes with no wait state and never raises PSLVERR.
- R2: A channel's active address changes only when its address register is written twice in a row, with no other access to that channel in between. The second write's PWDATA[15:0] becomes active and the channel is armed. A lone first write disarms the channel. Reading the address register returns the active address in bits 15:0, with zeros above.
- R3: A data access to a channel that is not armed completes with no wait state and issues no back-end request. A write is dropped and a read returns 0.
- R4: Each armed, in-range data read returns the value held from the channel's previous fetch (0 after reset). It also fetches from the active address, and the fetched value replaces the held value.
- R5: An armed, in-range data write issues exactly one back-end write to the active address. The write data is PWDATA[31:0] on channel A and PWDATA[7:0] on channel B.
- R6: A back-end access holds PREADY low until the acknowledge. Request, write enable and address stay steady while it waits.
- R7: Control register bit 15 is the error enable. It reads back at bit 15, with all other bits 0. When it is set, PSLVERR rises with PREADY on a back-end error or an out-of-range access. When it is clear, PSLVERR stays 0.
- R8: A data access whose active address exceeds the channel limit (parameters A_ADDR_MAX and B_ADDR_MAX) completes with no wait state and issues no request. A write is dropped and a read returns 0.
- R9: Channel B values are 8 bits wide. A read returns them zero-extended to 32 bits.
- R10: A read fetch that ends with the back-end error flag loads 0 into the held value.
- R11: The two channels keep separate active addresses, held values and error enables. At most one back-end request is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | PADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready |
| pslverr | output | 1 | APB error |
| a_req | output | 1 | Channel A back-end request |
| a_we | output | 1 | Channel A write enable |
| a_addr | output | 16 | Channel A register address |
| a_wdata | output | A_DATA_W | Channel A write data |
| a_rdata | input | A_DATA_W | Channel A read data |
| a_ack | input | 1 | Channel A acknowledge |
| a_err | input | 1 | Channel A error, valid with acknowledge |
| b_req | output | 1 | Channel B back-end request |
| b_we | output | 1 | Channel B write enable |
| b_addr | output | 16 | Channel B register address |
| b_wdata | output | B_DATA_W | Channel B write data |
| b_rdata | input | B_DATA_W | Channel B read data |
| b_ack | input | 1 | Channel B acknowledge |
| b_err | input | 1 | Channel B error, valid with acknowledge |

## Verification
The assertions assume that the host follows APB. PADDR, PWRITE and PWDATA are held from the setup phase until PREADY completes the transfer, and PENABLE rises only one cycle after PSEL. They also assume that each back end raises its acknowledge only while its request is high, for a single cycle.

The bench keeps within these assumptions. A single transfer task drives the bus on falling edges and holds every field until ready. The back-end model pulses the acknowledge once per request, after a fixed latency that differs per channel, so waits of several cycles and of a single cycle are both exercised.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

    // Register selected inside one channel's window
    typedef enum logic [1:0] {
        REG_ADDR = 2'd0,
        REG_DATA = 2'd1,
        REG_CTRL = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    // Per-channel access sequencer
    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_BUSY = 2'd1,
        CH_DONE = 2'd2
    } ch_state_e;

    localparam int ERR_EN_BIT = 15;
    localparam int TGT_ADDR_W = 16;
    localparam int HOST_DW    = 32;

endpackage

// File: rtl/ibr_decode.sv
module ibr_decode
    import ibr_pkg::*;
#(
    parameter int PADDR_W = 5
) (
    input  logic [PADDR_W-1:0] paddr,
    output logic               chan_b,
    output reg_sel_e           sel
);

    localparam int HI_W = PADDR_W - 5;

    logic upper_zero;

    generate
        if (HI_W > 0) begin : g_hi
            assign upper_zero = (paddr[PADDR_W-1:5] == '0);
        end else begin : g_nohi
            assign upper_zero = 1'b1;
        end
    endgenerate

    always_comb begin
        chan_b = paddr[4];
        sel    = REG_NONE;
        if (upper_zero && paddr[1:0] == 2'b00) begin
            unique case (paddr[3:2])
                2'd0:    sel = REG_ADDR;
                2'd1:    sel = REG_DATA;
                2'd2:    sel = REG_CTRL;
                default: sel = REG_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ibr_arm.sv
module ibr_arm #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_wr,
    input  logic          other_acc,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] active,
    output logic          armed
);

    logic half;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= '0;
            armed  <= 1'b0;
            half   <= 1'b0;
        end else if (addr_wr) begin
            if (half) begin
                active <= wdata;
                armed  <= 1'b1;
                half   <= 1'b0;
            end else begin
                armed  <= 1'b0;
                half   <= 1'b1;
            end
        end else if (other_acc) begin
            half <= 1'b0;
        end
    end

endmodule

// File: rtl/ibr_channel.sv
module ibr_channel
    import ibr_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter int unsigned ADDR_MAX = 32'h0000_FFFF,
    localparam int         WD_W     = (DATA_W > TGT_ADDR_W) ? DATA_W : TGT_ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc,
    input  reg_sel_e              sel,
    input  logic                  wr,
    input  logic [WD_W-1:0]       wdata,
    output logic [HOST_DW-1:0]    rdata_o,
    output logic                  ready_o,
    output logic                  err_o,
    output logic                  be_req,
    output logic                  be_we,
    output logic [TGT_ADDR_W-1:0] be_addr,
    output logic [DATA_W-1:0]     be_wdata,
    input  logic [DATA_W-1:0]     be_rdata,
    input  logic                  be_ack,
    input  logic                  be_err
);

    ch_state_e state, state_nx;

    logic [TGT_ADDR_W-1:0] active;
    logic                  armed;
    logic                  err_en;
    logic [DATA_W-1:0]     hold;
    logic [DATA_W-1:0]     out_q;
    logic [DATA_W-1:0]     wd_q;
    logic                  we_q;
    logic                  err_q;

    logic start, is_data, in_range, go_be, addr_wr, other_acc;
    logic [31:0] lim;

    assign lim       = ADDR_MAX;
    assign start     = acc && (state == CH_IDLE);
    assign is_data   = (sel == REG_DATA);
    assign in_range  = ({16'b0, active} <= lim);
    assign go_be     = start && is_data && armed && in_range;
    assign addr_wr   = start && (sel == REG_ADDR) && wr;
    assign other_acc = start && !((sel == REG_ADDR) && wr);

    ibr_arm #(.AW(TGT_ADDR_W)) u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_wr   (addr_wr),
        .other_acc (other_acc),
        .wdata     (wdata[TGT_ADDR_W-1:0]),
        .active    (active),
        .armed     (armed)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE: if (go_be)  state_nx = CH_BUSY;
            CH_BUSY: if (be_ack) state_nx = CH_DONE;
            CH_DONE:             state_nx = CH_IDLE;
            default:             state_nx = CH_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_en <= 1'b0;
            hold   <= '0;
            out_q  <= '0;
            wd_q   <= '0;
            we_q   <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (start && sel == REG_CTRL && wr)
                err_en <= wdata[ERR_EN_BIT];
            if (go_be) begin
                we_q  <= wr;
                wd_q  <= wdata[DATA_W-1:0];
                out_q <= wr ? '0 : hold;
                err_q <= 1'b0;
            end
            if (state == CH_BUSY && be_ack) begin
                err_q <= be_err && err_en;
                if (!we_q)
                    hold <= be_err ? '0 : be_rdata;
            end
        end
    end

    // Output process
    always_comb begin
        ready_o = 1'b0;
        rdata_o = '0;
        err_o   = 1'b0;
        unique case (state)
            CH_IDLE: begin
                if (acc && !go_be) begin
                    ready_o = 1'b1;
                    err_o   = is_data && armed && !in_range && err_en;
                    if (!wr) begin
                        unique case (sel)
                            REG_ADDR: rdata_o = HOST_DW'(active);
                            REG_CTRL: rdata_o = HOST_DW'(err_en) << ERR_EN_BIT;
                            default:  rdata_o = '0;
                        endcase
                    end
                end
            end
            CH_BUSY: ready_o = 1'b0;
            CH_DONE: begin
                ready_o = 1'b1;
                rdata_o = HOST_DW'(out_q);
                err_o   = err_q;
            end
            default: ready_o = 1'b0;
        endcase
    end

    assign be_req   = (state == CH_BUSY);
    assign be_we    = we_q;
    assign be_addr  = active;
    assign be_wdata = wd_q;

endmodule

// File: rtl/idx_reg_bridge.sv
module idx_reg_bridge
    import ibr_pkg::*;
#(
    parameter int          PADDR_W    = 5,
    parameter int          A_DATA_W   = 32,
    parameter int          B_DATA_W   = 8,
    parameter int unsigned A_ADDR_MAX = 32'h0000_FFFF,
    parameter int unsigned B_ADDR_MAX = 32'h0001_0000
) (
    input  logic                pclk,
    input  logic                presetn,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [PADDR_W-1:0]  paddr,
    input  logic [31:0]         pwdata,
    output logic [31:0]         prdata,
    output logic                pready,
    output logic                pslverr,
    output logic                a_req,
    output logic                a_we,
    output logic [15:0]         a_addr,
    output logic [A_DATA_W-1:0] a_wdata,
    input  logic [A_DATA_W-1:0] a_rdata,
    input  logic                a_ack,
    input  logic                a_err,
    output logic                b_req,
    output logic                b_we,
    output logic [15:0]         b_addr,
    output logic [B_DATA_W-1:0] b_wdata,
    input  logic [B_DATA_W-1:0] b_rdata,
    input  logic                b_ack,
    input  logic                b_err
);

    localparam int A_WD_W = (A_DATA_W > TGT_ADDR_W) ? A_DATA_W : TGT_ADDR_W;
    localparam int B_WD_W = (B_DATA_W > TGT_ADDR_W) ? B_DATA_W : TGT_ADDR_W;

    logic     chan_b;
    reg_sel_e sel;
    logic     access, acc_a, acc_b;
    logic [31:0] rd_a, rd_b;
    logic     rdy_a, rdy_b, er_a, er_b;

    ibr_decode #(.PADDR_W(PADDR_W)) u_dec (
        .paddr  (paddr),
        .chan_b (chan_b),
        .sel    (sel)
    );

    assign access = psel && penable && (sel != REG_NONE);
    assign acc_a  = access && !chan_b;
    assign acc_b  = access && chan_b;

    ibr_channel #(.DATA_W(A_DATA_W), .ADDR_MAX(A_ADDR_MAX)) u_cha (
        .clk      (pclk),
        .rst_n    (presetn),
        .acc      (acc_a),
        .sel      (sel),
        .wr       (pwrite),
        .wdata    (pwdata[A_WD_W-1:0]),
        .rdata_o  (rd_a),
        .ready_o  (rdy_a),
        .err_o    (er_a),
        .be_req   (a_req),
        .be_we    (a_we),
        .be_addr  (a_addr),
        .be_wdata (a_wdata),
        .be_rdata (a_rdata),
        .be_ack   (a_ack),
        .be_err   (a_err)
    );

    ibr_channel #(.DATA_W(B_DATA_W), .ADDR_MAX(B_ADDR_MAX)) u_chb (
        .clk      (pclk),
        .rst_n    (presetn),
        .acc      (acc_b),
        .sel      (sel),
        .wr       (pwrite),
        .wdata    (pwdata[B_WD_W-1:0]),
        .rdata_o  (rd_b),
        .ready_o  (rdy_b),
        .err_o    (er_b),
        .be_req   (b_req),
        .be_we    (b_we),
        .be_addr  (b_addr),
        .be_wdata (b_wdata),
        .be_rdata (b_rdata),
        .be_ack   (b_ack),
        .be_err   (b_err)
    );

    always_comb begin
        if (sel == REG_NONE) begin
            pready  = 1'b1;
            prdata  = '0;
            pslverr = 1'b0;
        end else if (chan_b) begin
            pready  = rdy_b;
            prdata  = rd_b;
            pslverr = er_b;
        end else begin
            pready  = rdy_a;
            prdata  = rd_a;
            pslverr = er_a;
        end
    end

endmodule

// File: rtl/ibr_checker.sv
module ibr_checker (
    input logic        pclk,
    input logic        presetn,
    input logic        psel,
    input logic        penable,
    input logic        pwrite,
    input logic        pready,
    input logic        pslverr,
    input logic        a_req,
    input logic        a_we,
    input logic [15:0] a_addr,
    input logic        a_ack,
    input logic        b_req,
    input logic        b_we,
    input logic [15:0] b_addr,
    input logic        b_ack
);

    // R6: request and address held until acknowledge
    p_a_hold_r6: assert property (@(posedge pclk) disable iff (!presetn)
        a_req && !a_ack |=> a_req && $stable(a_addr));
    p_b_hold_r6: assert property (@(posedge pclk) disable iff (!presetn)
        b_req && !b_ack |=> b_req && $stable(b_addr));

    // R5: a back-end access only follows a host access phase, direction preserved
    p_a_launch_r5: assert property (@(posedge pclk) disable iff (!presetn)
        $rose(a_req) |-> $past(psel && penable) && (a_we == $past(pwrite)));
    p_b_launch_r5: assert property (@(posedge pclk) disable iff (!presetn)
        $rose(b_req) |-> $past(psel && penable) && (b_we == $past(pwrite)));

    // R6: completed transfer leaves no request outstanding
    p_done_idle_r6: assert property (@(posedge pclk) disable iff (!presetn)
        psel && penable && pready |=> !a_req && !b_req);

    // R11: channels never request together
    p_excl_r11: assert property (@(posedge pclk) disable iff (!presetn)
        !(a_req && b_req));

    // R7: error only reported on a completing cycle
    p_err_ready_r7: assert property (@(posedge pclk) disable iff (!presetn)
        psel && penable && pslverr |-> pready);

endmodule

bind idx_reg_bridge ibr_checker u_chk (
    .pclk    (pclk),
    .presetn (presetn),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .pready  (pready),
    .pslverr (pslverr),
    .a_req   (a_req),
    .a_we    (a_we),
    .a_addr  (a_addr),
    .a_ack   (a_ack),
    .b_req   (b_req),
    .b_we    (b_we),
    .b_addr  (b_addr),
    .b_ack   (b_ack)
);

// File: tb/tb_idx_reg_bridge.sv
`timescale 1ns/1ps
module tb_idx_reg_bridge;

    localparam int LAT_A = 2;
    localparam int LAT_B = 0;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [4:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        a_req, a_we, a_ack, a_err;
    logic [15:0] a_addr;
    logic [31:0] a_wdata, a_rdata;
    logic        b_req, b_we, b_ack, b_err;
    logic [15:0] b_addr;
    logic [7:0]  b_wdata, b_rdata;

    int checks = 0, errors = 0;
    int n_ack_a = 0, n_ack_b = 0;
    int cnt_a = 0, cnt_b = 0;
    logic [31:0] mem_a [16];
    logic [7:0]  mem_b [16];

    always #2.5 pclk = ~pclk;

    idx_reg_bridge #(.B_ADDR_MAX(32'h0000_0FFF)) dut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr),
        .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_ack(a_ack), .a_err(a_err),
        .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_ack(b_ack), .b_err(b_err)
    );

    function automatic logic [31:0] init_a(int i);
        return 32'hA000_0000 + i * 32'h0101_0101;
    endfunction

    // Back-end register file model; address 0x00EE on channel A flags an error
    always @(posedge pclk) begin
        if (!presetn) begin
            a_ack <= 1'b0; a_err <= 1'b0; a_rdata <= '0; cnt_a <= 0;
            b_ack <= 1'b0; b_err <= 1'b0; b_rdata <= '0; cnt_b <= 0;
            for (int i = 0; i < 16; i++) begin
                mem_a[i] <= init_a(i);
                mem_b[i] <= 8'h30 + 8'(i);
            end
        end else begin
            if (a_req && !a_ack) begin
                if (cnt_a == LAT_A) begin
                    a_ack <= 1'b1;
                    a_err <= (a_addr == 16'h00EE);
                    cnt_a <= 0;
                    if (a_we) mem_a[a_addr[3:0]] <= a_wdata;
                    else      a_rdata <= mem_a[a_addr[3:0]];
                end else cnt_a <= cnt_a + 1;
            end else a_ack <= 1'b0;
            if (b_req && !b_ack) begin
                if (cnt_b == LAT_B) begin
                    b_ack <= 1'b1;
                    b_err <= 1'b0;
                    cnt_b <= 0;
                    if (b_we) mem_b[b_addr[3:0]] <= b_wdata;
                    else      b_rdata <= mem_b[b_addr[3:0]];
                end else cnt_b <= cnt_b + 1;
            end else b_ack <= 1'b0;
            if (a_ack) n_ack_a <= n_ack_a + 1;
            if (b_ack) n_ack_b <= n_ack_b + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apb(input logic wr, input logic [4:0] a, input logic [31:0] wd,
                       output logic [31:0] rd, output logic er, output int w);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = wd;
        @(negedge pclk);
        penable = 1'b1; w = 0;
        #1;
        while (!pready) begin
            @(negedge pclk); #1; w++;
        end
        rd = prdata; er = pslverr;
        @(posedge pclk); #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    logic [31:0] rd;
    logic        er;
    int          w;
    int          base;

    task automatic t_reset();
        apb(0, 5'h00, 0, rd, er, w); chk("R2 reset addr reg", rd, 0);
        apb(0, 5'h04, 0, rd, er, w); chk("R3 unarmed read zero", rd, 0);
        chk("R3 unarmed read no wait", w, 0);
        apb(0, 5'h08, 0, rd, er, w); chk("R7 reset ctrl", rd, 0);
        apb(0, 5'h0C, 0, rd, er, w); chk("R1 unmapped read", rd, 0);
        chk("R1 unmapped no err", {31'b0, er}, 0);
    endtask

    task automatic t_arm_read();
        apb(1, 5'h00, 32'h0001_2345, rd, er, w);
        apb(1, 5'h00, 32'h0001_2345, rd, er, w);
        apb(0, 5'h00, 0, rd, er, w); chk("R2 low 16 bits kept", rd, 32'h2345);
        apb(0, 5'h04, 0, rd, er, w); chk("R4 first read returns held", rd, 0);
        chk("R6 stall waits", {31'b0, w >= 1}, 1);
        apb(0, 5'h04, 0, rd, er, w); chk("R4 second read data", rd, init_a(5));
    endtask

    task automatic t_unarmed();
        apb(1, 5'h00, 3, rd, er, w);
        base = n_ack_a;
        apb(1, 5'h04, 32'hDEAD, rd, er, w);
        apb(0, 5'h04, 0, rd, er, w); chk("R3 single addr write read zero", rd, 0);
        chk("R3 no back-end access", n_ack_a - base, 0);
        apb(1, 5'h00, 7, rd, er, w);
        apb(0, 5'h08, 0, rd, er, w);
        apb(1, 5'h00, 7, rd, er, w);
        apb(0, 5'h04, 0, rd, er, w); chk("R2 broken pair stays unarmed", rd, 0);
        apb(1, 5'h00, 7, rd, er, w);
        apb(1, 5'h00, 7, rd, er, w);
        apb(0, 5'h04, 0, rd, er, w); chk("R4 held value kept across ignored", rd, init_a(5));
        apb(0, 5'h04, 0, rd, er, w); chk("R4 read addr 7", rd, init_a(7));
    endtask

    task automatic t_write();
        base = n_ack_a;
        apb(1, 5'h04, 32'hCAFE_F00D, rd, er, w);
        chk("R5 one back-end write", n_ack_a - base, 1);
        chk("R5 model updated", mem_a[7], 32'hCAFE_F00D);
        apb(0, 5'h04, 0, rd, er, w); chk("R4 stale before refetch", rd, init_a(7));
        apb(0, 5'h04, 0, rd, er, w); chk("R4 written value", rd, 32'hCAFE_F00D);
    endtask

    task automatic t_chan_b();
        apb(1, 5'h10, 3, rd, er, w);
        apb(1, 5'h10, 3, rd, er, w);
        apb(1, 5'h14, 32'h1234_56A5, rd, er, w);
        chk("R5 channel B low byte written", {24'b0, mem_b[3]}, 32'hA5);
        apb(0, 5'h14, 0, rd, er, w); chk("R4 channel B held zero", rd, 0);
        apb(0, 5'h14, 0, rd, er, w); chk("R9 zero-extended", rd, 32'h0000_00A5);
        apb(0, 5'h00, 0, rd, er, w); chk("R11 channel A addr intact", rd, 7);
    endtask

    task automatic t_error();
        apb(1, 5'h08, 32'hFFFF_FFFF, rd, er, w);
        apb(0, 5'h08, 0, rd, er, w); chk("R7 ctrl readback", rd, 32'h0000_8000);
        apb(0, 5'h18, 0, rd, er, w); chk("R11 channel B ctrl separate", rd, 0);
        apb(1, 5'h00, 32'hEE, rd, er, w);
        apb(1, 5'h00, 32'hEE, rd, er, w);
        apb(0, 5'h04, 0, rd, er, w);
        chk("R7 backend error raises pslverr", {31'b0, er}, 1);
        chk("R4 held value before error", rd, 32'hCAFE_F00D);
        apb(1, 5'h08, 0, rd, er, w);
        apb(0, 5'h04, 0, rd, er, w);
        chk("R10 error fetch held zero", rd, 0);
        chk("R7 disabled no pslverr", {31'b0, er}, 0);
    endtask

    task automatic t_range();
        apb(1, 5'h18, 32'h0000_8000, rd, er, w);
        apb(1, 5'h10, 32'h2000, rd, er, w);
        apb(1, 5'h10, 32'h2000, rd, er, w);
        base = n_ack_b;
        apb(1, 5'h14, 32'h77, rd, er, w);
        chk("R8 out of range write error", {31'b0, er}, 1);
        chk("R8 out of range no wait", w, 0);
        apb(0, 5'h14, 0, rd, er, w);
        chk("R8 out of range read zero", rd, 0);
        chk("R8 no back-end access", n_ack_b - base, 0);
        apb(1, 5'h18, 0, rd, er, w);
        apb(0, 5'h14, 0, rd, er, w);
        chk("R7 range error masked", {31'b0, er}, 0);
    endtask

    task automatic t_unmapped();
        apb(1, 5'h1C, 32'hFFFF_FFFF, rd, er, w);
        chk("R1 unmapped write no wait", w, 0);
        apb(0, 5'h10, 0, rd, er, w); chk("R1 B addr untouched", rd, 32'h2000);
        apb(0, 5'h00, 0, rd, er, w); chk("R1 A addr untouched", rd, 32'hEE);
        apb(0, 5'h18, 0, rd, er, w); chk("R1 B ctrl untouched", rd, 0);
    endtask

    initial begin
        repeat (20000) @(posedge pclk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge pclk);
        #1 presetn = 1'b1;
        t_reset();
        t_arm_read();
        t_unarmed();
        t_write();
        t_chan_b();
        t_error();
        t_range();
        t_unmapped();
        repeat (4) @(posedge pclk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule